// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a bus master read serial flash as if it were plain memory. A request on a small valid/ready port carries a byte offset into a fixed-size window. The engine answers it by running a complete flash read on the serial pins. It selects the chosen device and shifts out that device's read opcode and the offset bytes. It then clocks the configured number of dummy bytes, gathers four data bytes on one, two or four data lines, and releases the device. The four bytes come back as one 32-bit word.

Every chip select has its own 14-bit setup entry, so devices with different read commands can share the pins. The entry gives the opcode, the address length, the dummy length and the data lane mode. A mode input gives the pins to this engine. While that input is low, the pins belong to a separate command engine, and any bus request is refused at once with an error. Serial clock polarity, phase and divider are inputs shared with that command engine.

Top module: `xip_read_engine`

## Requirements
- R1: When `map_en` is 0, an accepted request produces `rsp_valid` with `rsp_err` = 1 in the cycle after acceptance, and no chip select goes low.
- R2: `cs_sel` value 0 selects no device, and value n+1 selects device n. A value of 0, or one that names a device index at or above NUM_CS, gives an immediate error response with every chip select left high.
- R3: A request whose offset plus 4 exceeds WIN_BYTES gives an immediate error response. An offset of exactly WIN_BYTES-4 is served.
- R4: The transaction starts with the 8-bit opcode from setup bits 7:0, sent most significant bit first on line 0. While opcode and address are sent, only line 0 is driven (`io_oe` = 0001).
- R5: The address phase sends (setup bits 9:8)+1 bytes on line 0. These are the low bytes of the offset, most significant bit first.
- R6: After the address, the engine gives 8×(setup bits 11:10) clock periods with no line driven. The opcode, address, dummy and data slots together add up to the total number of clock periods with the device selected.
- R7: Setup bits 13:12 pick the data lanes. Code 0 reads one bit per clock on line 1. Code 1 reads two bits per clock on lines 1:0, with line 1 the more significant. Code 3 reads four bits per clock on lines 3:0, with line 3 the most significant. Code 2 behaves as code 0.
- R8: Each data byte arrives most significant bit first. The first byte received lands in `rsp_data` bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24.
- R9: `sclk` rests at `cpol` when no device is selected. Each clock half lasts `sclk_div`+1 cycles. Input data is captured on the first edge of each period when `cpha` = 0, and on the second edge when `cpha` = 1.
- R10: During a transaction exactly one chip select is low: the one named by `cs_sel`. All are high otherwise.
- R11: `req_ready` is high only while idle. `rsp_valid` is a single-cycle pulse for each accepted request.
- R12: The setup entry used is the one at bits 14n+13:14n of `setup_words` for device n. Entries of other devices have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_en | input | 1 | 1: pins serve memory-mapped reads; 0: pins belong to the command engine |
| cs_sel | input | 3 | Device select code (0 none, n+1 device n) |
| setup_words | input | NUM_CS*14 | Per-device read setup entries |
| sclk_div | input | DIV_W | Serial clock half-period minus one, in cycles |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Capture on the second clock edge when 1 |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | ADDR_W | Byte offset in the window |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Read word, little-endian byte order |
| rsp_err | output | 1 | Request refused |
| sclk | output | 1 | Serial clock |
| cs_n | output | NUM_CS | Active-low chip selects |
| io_out | output | 4 | Serial data lines out |
| io_oe | output | 4 | Output enables per line |
| io_in | input | 4 | Serial data lines in |

## Verification
A wrong phase or slot count shows up at the pins within one transaction. It changes how many serial clocks the chip select stays low, and it moves the opcode or address bits the flash model captures. A fault in the lane or byte order corrupts `rsp_data` on the response pulse at the end of that same read. A wrong refusal decision shows one cycle after acceptance, either as a missing error pulse or as a chip select going low. Each read is therefore checked for its total low time, its captured command and address, its line enables and its returned word.

// File: rtl/xip_pkg.sv
`timescale 1ns/1ps
package xip_pkg;

  localparam int SLOT_W  = 7;
  localparam int SETUP_W = 14;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_DUMMY,
    ST_RECV,
    ST_RESP
  } xip_state_e;

  // Field order matches the bit positions of one setup entry.
  typedef struct packed {
    logic [1:0] lanes;    // 13:12
    logic [1:0] dummy;    // 11:10
    logic [1:0] addr_m1;  // 9:8
    logic [7:0] opcode;   // 7:0
  } xip_setup_t;

  // Serial clock periods needed to collect 32 data bits.
  function automatic logic [SLOT_W-1:0] data_slots(input logic [1:0] lanes);
    case (lanes)
      2'd3:    data_slots = SLOT_W'(8);
      2'd1:    data_slots = SLOT_W'(16);
      default: data_slots = SLOT_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/xip_req_check.sv
`timescale 1ns/1ps
module xip_req_check
  import xip_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int ADDR_W    = 24,
  parameter int WIN_BYTES = 1 << 20,
  localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                      map_en,
  input  logic [2:0]                cs_sel,
  input  logic [NUM_CS*SETUP_W-1:0] setup_words,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic                      reject,
  output logic [CS_W-1:0]           cs_idx,
  output xip_setup_t                setup
);

  localparam logic [3:0]      CS_LIM  = 4'(NUM_CS);
  localparam logic [ADDR_W:0] WIN_LIM = (ADDR_W+1)'(WIN_BYTES);

  logic [2:0]      sel_m1;
  logic            sel_ok;
  logic [ADDR_W:0] end_addr;
  logic            fits;

  always_comb begin
    sel_m1   = cs_sel - 3'd1;
    sel_ok   = (cs_sel != 3'd0) && ({1'b0, sel_m1} < CS_LIM);
    end_addr = {1'b0, req_addr} + (ADDR_W+1)'(4);
    fits     = (end_addr <= WIN_LIM);
    reject   = !map_en || !sel_ok || !fits;
    cs_idx   = sel_m1[CS_W-1:0];
  end

  always_comb begin
    setup = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (cs_idx == CS_W'(i)) setup = xip_setup_t'(setup_words[i*SETUP_W +: SETUP_W]);
    end
  end

endmodule

// File: rtl/xip_sclk_gen.sv
`timescale 1ns/1ps
module xip_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             run_nxt,
  input  logic [DIV_W-1:0] div,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk,
  output logic             sample_pulse,
  output logic             slot_end
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             half_q, half_d;
  logic             raw_q, raw_d;
  logic             tick;

  // A slot is two halves; input is taken at the mid-slot edge, outputs move at slot end.
  always_comb begin
    tick         = run && (cnt_q == div);
    sample_pulse = tick && !half_q;
    slot_end     = tick && half_q;
    cnt_d        = cnt_q;
    half_d       = half_q;
    if (!run) begin
      cnt_d  = '0;
      half_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      half_d = !half_q;
    end else begin
      cnt_d  = cnt_q + DIV_W'(1);
    end
    raw_d = run_nxt && (cpha ? !half_d : half_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
      raw_q  <= raw_d;
    end
  end

  assign sclk = cpol ^ raw_q;

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && $stable(div) && $past(run) |-> cnt_q <= div);

endmodule

// File: rtl/xip_rx_collect.sv
`timescale 1ns/1ps
module xip_rx_collect (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        shift_en,
  input  logic [1:0]  lanes,
  input  logic [3:0]  io_in,
  output logic [31:0] word
);

  logic [31:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (clear) begin
      sreg_d = '0;
    end else if (shift_en) begin
      case (lanes)
        2'd3:    sreg_d = {sreg_q[27:0], io_in};
        2'd1:    sreg_d = {sreg_q[29:0], io_in[1:0]};
        default: sreg_d = {sreg_q[30:0], io_in[1]};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  // First byte shifted in sits at the top; return it in the lowest byte lane.
  for (genvar b = 0; b < 4; b++) begin : g_swap
    assign word[b*8 +: 8] = sreg_q[(3-b)*8 +: 8];
  end

endmodule

// File: rtl/xip_read_engine.sv
`timescale 1ns/1ps
module xip_read_engine
  import xip_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int ADDR_W    = 24,
  parameter int WIN_BYTES = 1 << 20,
  parameter int DIV_W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      map_en,
  input  logic [2:0]                cs_sel,
  input  logic [NUM_CS*SETUP_W-1:0] setup_words,
  input  logic [DIV_W-1:0]          sclk_div,
  input  logic                      cpol,
  input  logic                      cpha,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic                      rsp_valid,
  output logic [31:0]               rsp_data,
  output logic                      rsp_err,
  output logic                      sclk,
  output logic [NUM_CS-1:0]         cs_n,
  output logic [3:0]                io_out,
  output logic [3:0]                io_oe,
  input  logic [3:0]                io_in
);

  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int TX_W = 40;
  localparam logic [ADDR_W:0] WIN_LIM = (ADDR_W+1)'(WIN_BYTES);

  xip_state_e        state_q, state_d;
  logic              err_q, err_d;
  logic [CS_W-1:0]   cs_idx_q, cs_idx_d;
  xip_setup_t        setup_q, setup_d;
  logic [SLOT_W-1:0] slots_q, slots_d;
  logic [TX_W-1:0]   tx_q, tx_d;
  logic [NUM_CS-1:0] cs_n_q;

  logic              chk_reject;
  logic [CS_W-1:0]   chk_idx;
  xip_setup_t        chk_setup;
  logic [31:0]       addr_left;
  logic              accept, run, run_d;
  logic              sample_pulse, slot_end;
  logic [31:0]       rx_word;

  xip_req_check #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)
  ) u_check (
    .map_en(map_en), .cs_sel(cs_sel), .setup_words(setup_words), .req_addr(req_addr),
    .reject(chk_reject), .cs_idx(chk_idx), .setup(chk_setup)
  );

  always_comb begin
    accept    = req_valid && (state_q == ST_IDLE);
    addr_left = 32'(req_addr) << {~chk_setup.addr_m1, 3'b000};
    run       = (state_q == ST_SEND) || (state_q == ST_DUMMY) || (state_q == ST_RECV);
    run_d     = (state_d == ST_SEND) || (state_d == ST_DUMMY) || (state_d == ST_RECV);
  end

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    err_d    = err_q;
    cs_idx_d = cs_idx_q;
    setup_d  = setup_q;
    slots_d  = slots_q;
    tx_d     = tx_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          err_d    = chk_reject;
          cs_idx_d = chk_idx;
          setup_d  = chk_setup;
          tx_d     = {chk_setup.opcode, addr_left};
          slots_d  = SLOT_W'({chk_setup.addr_m1, 3'b000}) + SLOT_W'(16);
          state_d  = chk_reject ? ST_RESP : ST_SEND;
        end
      end
      ST_SEND: begin
        if (slot_end) begin
          tx_d = {tx_q[TX_W-2:0], 1'b0};
          if (slots_q == SLOT_W'(1)) begin
            if (setup_q.dummy != 2'd0) begin
              state_d = ST_DUMMY;
              slots_d = SLOT_W'({setup_q.dummy, 3'b000});
            end else begin
              state_d = ST_RECV;
              slots_d = data_slots(setup_q.lanes);
            end
          end else begin
            slots_d = slots_q - SLOT_W'(1);
          end
        end
      end
      ST_DUMMY: begin
        if (slot_end) begin
          if (slots_q == SLOT_W'(1)) begin
            state_d = ST_RECV;
            slots_d = data_slots(setup_q.lanes);
          end else begin
            slots_d = slots_q - SLOT_W'(1);
          end
        end
      end
      ST_RECV: begin
        if (slot_end) begin
          if (slots_q == SLOT_W'(1)) state_d = ST_RESP;
          else                       slots_d = slots_q - SLOT_W'(1);
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      err_q    <= 1'b0;
      cs_idx_q <= '0;
      setup_q  <= '0;
      slots_q  <= '0;
      tx_q     <= '0;
    end else begin
      state_q  <= state_d;
      err_q    <= err_d;
      cs_idx_q <= cs_idx_d;
      setup_q  <= setup_d;
      slots_q  <= slots_d;
      tx_q     <= tx_d;
    end
  end

  // Registered chip selects, one flop per device
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_n_q[g] <= 1'b1;
      else        cs_n_q[g] <= !(run_d && (cs_idx_d == CS_W'(g)));
    end
  end

  xip_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run(run), .run_nxt(run_d), .div(sclk_div),
    .cpol(cpol), .cpha(cpha), .sclk(sclk), .sample_pulse(sample_pulse), .slot_end(slot_end)
  );

  xip_rx_collect u_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .shift_en((state_q == ST_RECV) && sample_pulse),
    .lanes(setup_q.lanes), .io_in(io_in), .word(rx_word)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_err   = rsp_valid && err_q;
  assign rsp_data  = (rsp_valid && !err_q) ? rx_word : 32'd0;
  assign cs_n      = cs_n_q;
  assign io_out    = {3'b000, tx_q[TX_W-1]};
  assign io_oe     = {3'b000, state_q == ST_SEND};

  // R1
  unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !map_en |=> rsp_valid && rsp_err);

  // R3
  window_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (({1'b0, req_addr} + (ADDR_W+1)'(4)) > WIN_LIM)
    |=> rsp_valid && rsp_err && (&cs_n));

  // R10
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R6
  drive_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|io_oe) |-> !(&cs_n));

  // R9
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> sclk == cpol);

endmodule

// File: tb/xip_read_engine_tb.sv
`timescale 1ns/1ps
module xip_read_engine_tb;

  localparam int NUM_CS = 4;
  localparam int ADDR_W = 24;
  localparam int WIN    = 1 << 20;
  localparam int SW     = 14;

  logic                 clk, rst_n, map_en, cpol, cpha, req_valid;
  logic [2:0]           cs_sel;
  logic [NUM_CS*SW-1:0] setup_words;
  logic [7:0]           sclk_div;
  logic [ADDR_W-1:0]    req_addr;
  logic [3:0]           io_in;
  wire                  req_ready, rsp_valid, rsp_err, sclk;
  wire  [31:0]          rsp_data;
  wire  [NUM_CS-1:0]    cs_n;
  wire  [3:0]           io_out, io_oe;

  int checks = 0;
  int errors = 0;

  xip_read_engine #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .WIN_BYTES(WIN), .DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .map_en(map_en), .cs_sel(cs_sel), .setup_words(setup_words),
    .sclk_div(sclk_div), .cpol(cpol), .cpha(cpha), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fmem(input logic [31:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd37;
    return (m + 8'h5A) ^ a[15:8];
  endfunction

  // ---------------- flash model ----------------
  int          cap_n;
  logic [39:0] cap_bits;
  bit          oe_bad;
  int          fl_nad, fl_base, fl_lanes;
  wire         fl_act = (cs_n != {NUM_CS{1'b1}});

  always @(posedge fl_act) begin
    cap_n    = 0;
    cap_bits = '0;
    oe_bad   = 0;
  end

  task automatic fl_drive(input int slot);
    int          j;
    logic [63:0] m;
    logic [31:0] a, s;
    logic [3:0]  v;
    j = slot - fl_base;
    if (j >= 0 && j < 32 / fl_lanes) begin
      m = (64'd1 << (8 * fl_nad)) - 64'd1;
      a = cap_bits[31:0] & m[31:0];
      s = {fmem(a), fmem(a + 1), fmem(a + 2), fmem(a + 3)};
      case (fl_lanes)
        4:       v = s[31 - 4*j -: 4];
        2:       v = {2'b00, s[31 - 2*j -: 2]};
        default: v = {2'b00, s[31 - j], 1'b0};
      endcase
      io_in <= #1 v;
    end
  endtask

  always @(sclk) begin
    if (fl_act) begin
      if ((sclk != cpol) ^ cpha) begin
        if (cap_n < 8 + 8 * fl_nad) begin
          cap_bits = {cap_bits[38:0], io_out[0]};
          if (io_oe != 4'b0001) oe_bad = 1;
        end else if (io_oe != 4'b0000) begin
          oe_bad = 1;
        end
        cap_n++;
      end else begin
        fl_drive(cap_n);
      end
    end
  end

  // ---------------- scenarios ----------------
  task automatic t_read(input int cs, input logic [7:0] op, input int nad, input int dmy,
                        input int lcode, input bit pol, input bit pha, input int div,
                        input logic [23:0] addr);
    int                slots, cs_low, n, lanes;
    logic [NUM_CS-1:0] cs_seen;
    bit                ready_bad, got;
    logic [63:0]       m;
    logic [31:0]       a, exp;
    logic [1:0]        nad_m1;
    @(negedge clk);
    map_en = 1'b1;
    cs_sel = 3'(cs + 1);
    nad_m1 = 2'(nad - 1);
    setup_words[cs*SW +: SW] = {2'(lcode), 2'(dmy), nad_m1, op};
    cpol = pol; cpha = pha; sclk_div = 8'(div);
    lanes    = (lcode == 3) ? 4 : (lcode == 1) ? 2 : 1;
    fl_nad   = nad; fl_lanes = lanes;
    fl_base  = 8 + 8*nad + 8*dmy;
    slots    = fl_base + 32 / lanes;
    repeat (2) @(negedge clk);
    chk(sclk == pol, "R9 idle clock level", 64'(sclk), 64'(pol));
    req_valid = 1'b1; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    cs_low = 0; cs_seen = '0; ready_bad = 0; got = 0;
    for (n = 0; n < 5000; n++) begin
      if (rsp_valid) begin got = 1; break; end
      if (fl_act) cs_low++;
      cs_seen |= ~cs_n;
      if (req_ready) ready_bad = 1;
      @(negedge clk);
    end
    m   = (64'd1 << (8 * nad)) - 64'd1;
    a   = 32'(addr) & m[31:0];
    exp = {fmem(a + 3), fmem(a + 2), fmem(a + 1), fmem(a)};
    chk(got, "R11 response arrives", 64'(got), 64'd1);
    chk(rsp_err == 1'b0, "R2 valid request not refused", 64'(rsp_err), 64'd0);
    chk(rsp_data == exp, "R7 R8 data word lanes and byte order", 64'(rsp_data), 64'(exp));
    chk(cap_bits[8*nad +: 8] == op, "R4 opcode sent first", 64'(cap_bits[8*nad +: 8]), 64'(op));
    chk((cap_bits[31:0] & m[31:0]) == a, "R5 address bytes", 64'(cap_bits[31:0] & m[31:0]), 64'(a));
    chk(cap_n == slots, "R6 total clock periods incl dummy", 64'(cap_n), 64'(slots));
    chk(cs_low == slots * 2 * (div + 1), "R9 half period length", 64'(cs_low), 64'(slots * 2 * (div + 1)));
    chk(cs_seen == NUM_CS'(1 << cs), "R10 R12 selected device only", 64'(cs_seen), 64'(1 << cs));
    chk(!oe_bad, "R4 R6 line enables per phase", 64'(oe_bad), 64'd0);
    chk(!ready_bad, "R11 ready low while busy", 64'(ready_bad), 64'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 single cycle response", 64'(rsp_valid), 64'd0);
    chk(sclk == pol && cs_n == {NUM_CS{1'b1}}, "R9 R10 idle after read", {63'd0, sclk}, 64'(pol));
  endtask

  task automatic t_reject(input string tag, input bit mapped, input logic [2:0] sel,
                          input logic [23:0] addr);
    @(negedge clk);
    map_en = mapped; cs_sel = sel;
    req_valid = 1'b1; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_err, {tag, " error pulse next cycle"}, {62'd0, rsp_valid, rsp_err}, 64'd3);
    chk(cs_n == {NUM_CS{1'b1}}, {tag, " no chip select"}, 64'(cs_n), 64'hF);
    @(negedge clk);
    chk(!rsp_valid && cs_n == {NUM_CS{1'b1}}, {tag, " R11 pulse ends"}, 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; map_en = 1'b0; cs_sel = 3'd0; cpol = 1'b0; cpha = 1'b0;
    sclk_div = 8'd0; req_valid = 1'b0; req_addr = '0; io_in = 4'h0;
    cap_n = 0; cap_bits = '0; oe_bad = 0; fl_nad = 1; fl_base = 0; fl_lanes = 1;
    for (int i = 0; i < NUM_CS; i++) setup_words[i*SW +: SW] = SW'(14'h00F0 | i);
    repeat (3) @(negedge clk);
    chk(cs_n == {NUM_CS{1'b1}} && !rsp_valid && io_oe == 4'h0, "R10 reset state",
        {55'd0, cs_n, rsp_valid, io_oe}, {55'd0, 4'hF, 1'b0, 4'h0});
    chk(req_ready && sclk == 1'b0, "R11 R9 reset ready and clock", {62'd0, req_ready, sclk}, 64'd2);
    rst_n = 1'b1;
    // single lane, mode 0, fastest clock
    t_read(0, 8'h03, 3, 0, 0, 1'b0, 1'b0, 0, 24'h012345);
    // dual lane, one dummy byte, mode 3
    t_read(1, 8'h3B, 3, 1, 1, 1'b1, 1'b1, 1, 24'h0ABCDE);
    // quad lane, four address bytes, last word of the window (R3 boundary)
    t_read(2, 8'h6B, 4, 2, 3, 1'b0, 1'b1, 2, 24'h0FFFFC);
    // reserved lane code 2 behaves as single; one address byte; three dummy bytes
    t_read(3, 8'hEB, 1, 3, 2, 1'b1, 1'b0, 0, 24'h0000A7);
    // quad, two address bytes, device 0 setup rewritten
    t_read(0, 8'h0B, 2, 1, 3, 1'b1, 1'b1, 0, 24'h054321);
    t_reject("R3 window overrun", 1'b1, 3'd1, 24'h0FFFFD);
    t_reject("R2 select none", 1'b1, 3'd0, 24'h000100);
    t_reject("R2 select beyond devices", 1'b1, 3'd5, 24'h000100);
    t_reject("R1 command mode", 1'b0, 3'd1, 24'h000100);
    // engine recovers after refusals
    t_read(1, 8'h13, 2, 0, 0, 1'b0, 1'b0, 1, 24'h00BEEF);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule